// File: doc/BRIEF.md
# Cartridge Bank Mapper with Tilt-Sensor Register Window

This block is the cartridge-side register logic seen by an 8-bit CPU on a 16-bit address bus. Writes that land in the cartridge ROM address range set the ROM bank and the RAM bank. The 8 KiB external-RAM window at `0xA000`–`0xBFFF` does not reach memory. It holds a small register map instead.

The register map returns two 12-bit tilt values, one per axis, each split into a low byte and a high byte. It also returns the data-out bit of a serial EEPROM. Raw 32-bit signed sensor samples arrive on parallel inputs. They are converted to an offset-centred 12-bit value and latched only when a periodic sample strobe pulses, so repeated reads within one period return the same value.

A CPU write to the EEPROM control offset is passed on to an external EEPROM protocol engine as a one-cycle strobe with its data byte. Read data is registered: it appears one clock after the address is presented.

Top module: `tilt_mapper_regs`

## Requirements
- R1: Synchronous active-high reset clears `rom_bank` and `ram_bank` to 0. It also sets both tilt latches to 0x7FF, so with a sensor present, offset 0x20 reads 0xFF and offset 0x30 reads 0x07.
- R2: A write whose address bits [15:13] equal 1 loads `rom_bank` with data bits [6:0]. The new value is visible on the next clock.
- R3: A write whose address bits [15:13] equal 2 loads `ram_bank` with data bits [3:0] only when the data is below 0x10. A data value of 0x10 or more leaves `ram_bank` unchanged.
- R4: Writes with address bits [15:13] equal to 0 or 3 change neither bank register.
- R5: In the window (address bits [15:13] equal 5), address bits [7:4] select the register, and offsets 0x0, 0x1, 0x6 and 0x7 read 0x00.
- R6: Each axis latch holds the 12-bit value ((−raw) arithmetically shifted right by 21) + 2047. Offset 0x2 reads bits [7:0] of X and offset 0x3 reads bits [11:8] of X, zero-extended. Offsets 0x4 and 0x5 do the same for Y.
- R7: While `sensor_present` is 0, offsets 0x2 and 0x4 read 0xFF and offsets 0x3 and 0x5 read 0x07.
- R8: Offset 0x8 reads `ee_dout` in bit 0 with bits [7:1] zero. Offsets 0x9 through 0xF read 0xFF.
- R9: A write in the window at offset 0x8 produces `ee_wr` high for exactly one cycle on the next clock, with `ee_wdata` equal to the written byte. No other write raises `ee_wr`.
- R10: The tilt latches load only on a clock where `sample_stb` is 1. A change of the raw inputs without a strobe does not change the read value.
- R11: `rd_data` is registered from the address presented on the previous clock. An address outside the window reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| sample_stb | input | 1 | Periodic sample strobe |
| sensor_present | input | 1 | 1 when a tilt sensor is fitted |
| raw_x | input | 32 | Signed raw X sample |
| raw_y | input | 32 | Signed raw Y sample |
| ee_dout | input | 1 | EEPROM serial data-out bit |
| rd_data | output | 8 | Registered read data |
| rom_bank | output | 7 | Selected ROM bank |
| ram_bank | output | 4 | Selected RAM bank |
| ee_wr | output | 1 | One-cycle EEPROM control write strobe |
| ee_wdata | output | 8 | EEPROM control write data |

## Verification
Tilt conversion is tried in three ways:
- Directed raw values: zero, the most negative and most positive 32-bit numbers, and values just either side of a 2^21 step. These separate an arithmetic shift from a logical one, and a correct negation from a missing one.
- Random raw pairs: these show the X and Y paths are not swapped and that the low and high bytes are split at bit 8.
- Raw changes without a strobe: these separate latch-on-strobe from pass-through.

Bank handling is tried with random writes over all four ROM-space regions, including RAM-bank data on both sides of 0x10, so a wrong region decode or an unguarded RAM-bank load shows up as a bank mismatch.

Every offset of the window is swept with the sensor fitted and absent and with both EEPROM bit values. This tells the zero, fill, tilt and EEPROM decodes apart.

// File: rtl/tilt_mapper_pkg.sv
package tilt_mapper_pkg;
  localparam logic [2:0] RGN_ROM_SEL = 3'd1;
  localparam logic [2:0] RGN_RAM_SEL = 3'd2;
  localparam logic [2:0] RGN_WINDOW  = 3'd5;

  typedef enum logic [3:0] {
    OFS_Z0   = 4'h0,
    OFS_Z1   = 4'h1,
    OFS_XLO  = 4'h2,
    OFS_XHI  = 4'h3,
    OFS_YLO  = 4'h4,
    OFS_YHI  = 4'h5,
    OFS_Z6   = 4'h6,
    OFS_Z7   = 4'h7,
    OFS_EE   = 4'h8
  } ofs_e;
endpackage

// File: rtl/tilt_axis.sv
module tilt_axis #(
  parameter int RAW_W  = 32,
  parameter int TILT_W = 12,
  parameter int SHIFT  = 21
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb,
  input  logic signed [RAW_W-1:0]  raw,
  output logic [TILT_W-1:0]        tilt
);
  localparam logic signed [RAW_W-1:0] CENTER = RAW_W'((1 << (TILT_W-1)) - 1);

  logic signed [RAW_W-1:0] negated;
  logic signed [RAW_W-1:0] shifted;
  logic signed [RAW_W-1:0] centred;

  always_comb begin
    negated = -raw;
    shifted = negated >>> SHIFT;
    centred = shifted + CENTER;
  end

  always_ff @(posedge clk) begin
    if (rst)      tilt <= CENTER[TILT_W-1:0];
    else if (stb) tilt <= centred[TILT_W-1:0];
  end
endmodule

// File: rtl/bank_regs.sv
module bank_regs
  import tilt_mapper_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  wr,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ee_wr,
  output logic [DATA_W-1:0]     ee_wdata
);
  localparam int RAM_LIMIT = 1 << RAM_BANK_W;

  logic [2:0] region;
  logic [3:0] offset;
  logic       ram_ok;

  always_comb begin
    region = addr[ADDR_W-1 -: 3];
    offset = addr[7:4];
    ram_ok = (int'(wdata) < RAM_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank <= '0;
      ram_bank <= '0;
      ee_wr    <= 1'b0;
      ee_wdata <= '0;
    end else begin
      ee_wr <= 1'b0;
      if (wr) begin
        if (region == RGN_ROM_SEL)
          rom_bank <= wdata[ROM_BANK_W-1:0];
        if (region == RGN_RAM_SEL && ram_ok)
          ram_bank <= wdata[RAM_BANK_W-1:0];
        if (region == RGN_WINDOW && offset == OFS_EE) begin
          ee_wr    <= 1'b1;
          ee_wdata <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/reg_readmux.sv
module reg_readmux
  import tilt_mapper_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TILT_W = 12
) (
  input  logic              in_window,
  input  logic [3:0]        offset,
  input  logic              present,
  input  logic [TILT_W-1:0] tilt_x,
  input  logic [TILT_W-1:0] tilt_y,
  input  logic              ee_bit,
  output logic [DATA_W-1:0] value
);
  localparam int WW = 2 * DATA_W;
  localparam logic [WW-1:0] IDLE_TILT = WW'((1 << (TILT_W-1)) - 1);

  logic [WW-1:0] wx, wy;

  always_comb begin
    wx = '0;
    wy = '0;
    wx[TILT_W-1:0] = tilt_x;
    wy[TILT_W-1:0] = tilt_y;
    if (!present) begin
      wx = IDLE_TILT;
      wy = IDLE_TILT;
    end
    value = '1;
    if (in_window) begin
      unique case (offset)
        OFS_Z0, OFS_Z1, OFS_Z6, OFS_Z7: value = '0;
        OFS_XLO: value = wx[DATA_W-1:0];
        OFS_XHI: value = wx[WW-1:DATA_W];
        OFS_YLO: value = wy[DATA_W-1:0];
        OFS_YHI: value = wy[WW-1:DATA_W];
        OFS_EE:  value = {{(DATA_W-1){1'b0}}, ee_bit};
        default: value = '1;
      endcase
    end
  end
endmodule

// File: rtl/tilt_mapper_regs.sv
module tilt_mapper_regs
  import tilt_mapper_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RAW_W      = 32,
  parameter int TILT_W     = 12,
  parameter int SHIFT      = 21,
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_wr,
  input  logic                    sample_stb,
  input  logic                    sensor_present,
  input  logic signed [RAW_W-1:0] raw_x,
  input  logic signed [RAW_W-1:0] raw_y,
  input  logic                    ee_dout,
  output logic [DATA_W-1:0]       rd_data,
  output logic [ROM_BANK_W-1:0]   rom_bank,
  output logic [RAM_BANK_W-1:0]   ram_bank,
  output logic                    ee_wr,
  output logic [DATA_W-1:0]       ee_wdata
);
  localparam int AXES = 2;

  logic signed [RAW_W-1:0] raw_arr  [AXES];
  logic [TILT_W-1:0]       tilt_arr [AXES];
  logic [DATA_W-1:0]       rd_next;

  assign raw_arr[0] = raw_x;
  assign raw_arr[1] = raw_y;

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    tilt_axis #(.RAW_W(RAW_W), .TILT_W(TILT_W), .SHIFT(SHIFT)) u_axis (
      .clk  (clk),
      .rst  (rst),
      .stb  (sample_stb),
      .raw  (raw_arr[g]),
      .tilt (tilt_arr[g])
    );
  end

  bank_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)
  ) u_banks (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr       (bus_wr),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ee_wr    (ee_wr),
    .ee_wdata (ee_wdata)
  );

  reg_readmux #(.DATA_W(DATA_W), .TILT_W(TILT_W)) u_mux (
    .in_window (bus_addr[ADDR_W-1 -: 3] == RGN_WINDOW),
    .offset    (bus_addr[7:4]),
    .present   (sensor_present),
    .tilt_x    (tilt_arr[0]),
    .tilt_y    (tilt_arr[1]),
    .ee_bit    (ee_dout),
    .value     (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '1;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/tilt_mapper_chk.sv
module tilt_mapper_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  bus_wr,
  input logic                  sensor_present,
  input logic                  ee_dout,
  input logic [DATA_W-1:0]     rd_data,
  input logic [ROM_BANK_W-1:0] rom_bank,
  input logic [RAM_BANK_W-1:0] ram_bank,
  input logic                  ee_wr,
  input logic [DATA_W-1:0]     ee_wdata
);
  logic [2:0] rgn;
  logic [3:0] ofs;
  assign rgn = bus_addr[ADDR_W-1 -: 3];
  assign ofs = bus_addr[7:4];

  // R2
  rom_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && rgn == 3'd1) |=> rom_bank == $past(bus_wdata[ROM_BANK_W-1:0]));

  // R3
  ram_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && rgn == 3'd2 && bus_wdata >= 8'h10) |=> $stable(ram_bank));

  // R4
  other_rgn_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (rgn == 3'd0 || rgn == 3'd3)) |=> ($stable(rom_bank) && $stable(ram_bank)));

  // R9
  ee_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && rgn == 3'd5 && ofs == 4'h8) |=> (ee_wr && ee_wdata == $past(bus_wdata)));

  // R9
  ee_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && rgn == 3'd5 && ofs == 4'h8) |=> !ee_wr);

  // R5
  zero_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    (rgn == 3'd5 && (ofs == 4'h0 || ofs == 4'h1 || ofs == 4'h6 || ofs == 4'h7)) |=> rd_data == '0);

  // R7
  absent_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (rgn == 3'd5 && !sensor_present && (ofs == 4'h2 || ofs == 4'h4)) |=> rd_data == 8'hFF);

  // R8
  ee_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rgn == 3'd5 && ofs == 4'h8) |=> rd_data == {7'd0, $past(ee_dout)});

  // R11
  outside_chk: assert property (@(posedge clk) disable iff (rst)
    (rgn != 3'd5) |=> rd_data == 8'hFF);
endmodule

bind tilt_mapper_regs tilt_mapper_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
  .sensor_present(sensor_present), .ee_dout(ee_dout), .rd_data(rd_data),
  .rom_bank(rom_bank), .ram_bank(ram_bank), .ee_wr(ee_wr), .ee_wdata(ee_wdata)
);

// File: tb/tilt_mapper_regs_test.sv
`timescale 1ns/1ps
module tilt_mapper_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_wr = 1'b0;
  logic        sample_stb = 1'b0;
  logic        sensor_present = 1'b1;
  logic signed [31:0] raw_x = 32'sd0;
  logic signed [31:0] raw_y = 32'sd0;
  logic        ee_dout = 1'b0;
  logic [7:0]  rd_data;
  logic [6:0]  rom_bank;
  logic [3:0]  ram_bank;
  logic        ee_wr;
  logic [7:0]  ee_wdata;

  int tests = 0;
  int fails = 0;
  logic [6:0] m_rom = '0;
  logic [3:0] m_ram = '0;
  int m_tx = 12'h7FF;
  int m_ty = 12'h7FF;
  bit done = 0;

  always #2.5 clk = ~clk;

  tilt_mapper_regs uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .sample_stb(sample_stb), .sensor_present(sensor_present), .raw_x(raw_x), .raw_y(raw_y),
    .ee_dout(ee_dout), .rd_data(rd_data), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .ee_wr(ee_wr), .ee_wdata(ee_wdata)
  );

  function automatic int tilt_of(input logic signed [31:0] raw);
    logic signed [31:0] n;
    n = -raw;
    n = n >>> 21;
    return (n + 2047) & 12'hFFF;
  endfunction

  function automatic logic [7:0] expect_read(input logic [15:0] a);
    int t;
    if (a[15:13] != 3'd5) return 8'hFF;
    case (a[7:4])
      4'h0, 4'h1, 4'h6, 4'h7: return 8'h00;
      4'h2, 4'h3: t = sensor_present ? m_tx : 12'h7FF;
      4'h4, 4'h5: t = sensor_present ? m_ty : 12'h7FF;
      4'h8: return {7'd0, ee_dout};
      default: return 8'hFF;
    endcase
    if (a[4]) return 8'(t >> 8);
    return 8'(t);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
    logic want_ee;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a[15:13] == 3'd1) m_rom = d[6:0];
    if (a[15:13] == 3'd2 && d < 8'h10) m_ram = d[3:0];
    want_ee = (a[15:13] == 3'd5 && a[7:4] == 4'h8);
    check(req, rom_bank, m_rom);
    check(req, ram_bank, m_ram);
    check(req, ee_wr, want_ee);
    if (want_ee) check(req, ee_wdata, d);
    @(negedge clk);
    check(req, ee_wr, 0);
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(req, rd_data, expect_read(a));
  endtask

  task automatic do_sample(input logic signed [31:0] x, input logic signed [31:0] y);
    @(negedge clk);
    raw_x = x; raw_y = y; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    m_tx = tilt_of(x); m_ty = tilt_of(y);
  endtask

  task automatic read_tilt(input string req);
    for (int o = 2; o <= 5; o++) do_read(16'hA000 | 16'(o << 4), req);
  endtask

  initial begin
    #(5.0 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7341);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", rom_bank, 0);
    check("R1", ram_bank, 0);
    do_read(16'hA020, "R1");
    do_read(16'hA030, "R1");
    check("R1", rd_data, 8'h07);

    // R2, R3, R4 directed
    do_write(16'h2000, 8'hFF, "R2");
    do_write(16'h3FFF, 8'h05, "R2");
    do_write(16'h4000, 8'h0F, "R3");
    do_write(16'h5000, 8'h10, "R3");
    do_write(16'h4000, 8'hA3, "R3");
    do_write(16'h0000, 8'h55, "R4");
    do_write(16'h6000, 8'h33, "R4");

    // R9 forwarding and non-forwarding
    do_write(16'hA080, 8'hC3, "R9");
    do_write(16'hB08F, 8'h41, "R9");
    do_write(16'hA090, 8'h77, "R9");
    do_write(16'hA020, 8'h12, "R9");

    // R5, R8, R11: sweep offsets, both ee values, sensor on/off
    for (int p = 0; p < 2; p++) begin
      sensor_present = p[0];
      for (int e = 0; e < 2; e++) begin
        ee_dout = e[0];
        for (int o = 0; o < 16; o++)
          do_read(16'hA000 | 16'(o << 4), (o < 2 || o == 6 || o == 7) ? "R5" :
                  (o >= 8) ? "R8" : (p == 0 ? "R7" : "R6"));
      end
    end
    do_read(16'h8080, "R11");
    do_read(16'hC020, "R11");

    // R6 directed corners
    sensor_present = 1'b1;
    do_sample(32'sd0, -32'sd1);
    read_tilt("R6");
    do_sample(32'h80000000, 32'h7FFFFFFF);
    read_tilt("R6");
    do_sample(32'sd2097152, -32'sd2097152);
    read_tilt("R6");
    do_sample(32'sd2097151, -32'sd2097153);
    read_tilt("R6");

    // R10: raw changes without strobe
    @(negedge clk);
    raw_x = 32'h12345678; raw_y = -32'sd99999999;
    repeat (3) @(negedge clk);
    read_tilt("R10");

    // R7 with non-centre latches
    sensor_present = 1'b0;
    read_tilt("R7");
    sensor_present = 1'b1;

    // random mix
    for (int i = 0; i < 200; i++) begin
      int k = $urandom_range(0, 3);
      if (k == 0) begin
        do_sample($urandom, $urandom);
        read_tilt("R6");
      end else if (k == 1) begin
        logic [15:0] a = 16'($urandom_range(0, 16'h7FFF));
        do_write(a, 8'($urandom), a[15:13] == 3'd1 ? "R2" : a[15:13] == 3'd2 ? "R3" : "R4");
      end else if (k == 2) begin
        logic [15:0] a = 16'hA000 | 16'($urandom_range(0, 16'h1FFF));
        do_write(a, 8'($urandom), "R9");
      end else begin
        ee_dout = 1'($urandom);
        sensor_present = ($urandom_range(0, 3) != 0);
        do_read(16'($urandom), "R11");
        sensor_present = 1'b1;
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule